// File: doc/BRIEF.md
# Reset Strap Sequencer

This block is a small sequencer of the kind placed in board glue logic next to a host processor. It owns the processor's active-low hard-reset line and a set of configuration straps that share pins with normal functions. When the power-good input goes high, it captures a configuration word. It drives the PLL strap group first, because that group needs a long setup time. It then drives the general-purpose strap group a few cycles ahead of reset release. After release it holds every strap for a short window and then releases the pins to high impedance.

The power-good input also acts as the reset request. Pulling it low at any point returns the block to its reset state at once, and the whole sequence restarts when it rises again. The PLL setup window is given in microseconds and a clock frequency, and the block converts it to cycles. The general-purpose setup window and the hold window are given in cycles. A mask parameter marks which general-purpose strap bits the board uses. Unused bits are never driven.

The sequence moves through these states in order: reset idle, PLL strap drive, all-strap drive, reset release, hold, and tri-state.

Top module: `rststrap_seq`

## Requirements
- R1: While `pwr_ok` is low, `hreset_n` is 0, every output-enable bit is 0, `seq_done` is 0 and both strap value buses read 0.
- R2: All bits of `pll_strap_oe` go high on the first clock edge that samples `pwr_ok` high. They stay high for at least PLL_SETUP_CYC cycles before `hreset_n` rises.
- R3: The used bits of `gp_strap_oe` go high exactly STRAP_SETUP_CYC cycles before `hreset_n` rises. STRAP_SETUP_CYC is at least 4.
- R4: `hreset_n` is registered. Once it has risen it stays high until `pwr_ok` falls.
- R5: After `hreset_n` rises, every enabled strap stays driven for HOLD_CYC+1 further cycles, with HOLD_CYC at least 2. The enables therefore never fall on the edge that releases reset.
- R6: Both strap buses output the configuration inputs as sampled on the first edge after `pwr_ok` rises. Later input changes have no effect until the next reset request.
- R7: After the hold window, every output-enable bit is 0 and `seq_done` is 1. This state persists until `pwr_ok` falls.
- R8: A low level on `pwr_ok` in any state, including mid-setup and mid-hold, forces the R1 state without waiting for a clock. The next rise of `pwr_ok` starts the full sequence again.
- R9: A general-purpose strap bit whose `GP_USE_MASK` bit is 0 has its output-enable bit and its value bit held at 0.
- R10: PLL_SETUP_CYC equals ceil(CLK_HZ × PLL_SETUP_US / 1,000,000). `hreset_n` rises on edge PLL_SETUP_CYC+1, counting the edges on which `pwr_ok` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| pwr_ok | input | 1 | Power good; low is a reset request (asynchronous assert) |
| cfg_pll_i | input | PLL_W | PLL strap configuration word |
| cfg_gp_i | input | GP_W | General-purpose strap word (e.g. board revision) |
| hreset_n | output | 1 | Active-low hard reset to the processor |
| pll_strap_o | output | PLL_W | PLL strap values |
| pll_strap_oe | output | PLL_W | Per-bit output enable for PLL straps |
| gp_strap_o | output | GP_W | General-purpose strap values |
| gp_strap_oe | output | GP_W | Per-bit output enable for general-purpose straps |
| seq_done | output | 1 | Sequence complete and all strap pins released |

## Verification
The bench aims at the edges of each window.

- **General-purpose setup start.** The bench checks the exact cycle in which the general-purpose enables rise. A counter loaded one short or one long would move this window, and the design would then miss the four-cycle setup.
- **Hold window.** The bench checks the exact cycle in which all enables fall. A design that tri-stated the pins on the reset-release edge would remove the hold entirely.
- **Reset requests mid-sequence.** The bench drops `pwr_ok` during the all-strap window and again during the hold window. A design that ignored these requests, or kept stale counter values, would release reset too early on the next pass.
- **Capture and masking.** The bench changes the configuration inputs while the straps are driven and again after completion. A transparent capture register would pass these changes to the pins. With all-ones input, the bench confirms that masked-off bits stay 0.

// File: rtl/rststrap_pkg.sv
package rststrap_pkg;

   typedef enum logic [2:0] {
      ST_IDLE_RESET    = 3'd0,
      ST_DRIVE_PLL     = 3'd1,
      ST_DRIVE_ALL     = 3'd2,
      ST_RELEASE_RESET = 3'd3,
      ST_HOLD          = 3'd4,
      ST_TRISTATE      = 3'd5
   } seq_state_e;

endpackage

// File: rtl/rststrap_timer.sv
module rststrap_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/rststrap_fsm.sv
module rststrap_fsm
   import rststrap_pkg::*;
#(
   parameter int PLL_CYC   = 20,
   parameter int SETUP_CYC = 4,
   parameter int HOLD_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic capture_en,
   output logic hreset_n,
   output logic pll_drive,
   output logic gp_drive,
   output logic done
);

   localparam int MAX_LEN = (PLL_CYC > HOLD_CYC) ? PLL_CYC : HOLD_CYC;
   localparam int CNT_W   = $clog2(MAX_LEN + 1);
   localparam logic [CNT_W-1:0] LD_PLL   = CNT_W'(PLL_CYC - SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);

   seq_state_e       state_q, state_d;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;

   rststrap_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state_q)
         ST_IDLE_RESET: begin
            state_d  = ST_DRIVE_PLL;
            tmr_load = 1'b1;
            tmr_val  = LD_PLL;
         end
         ST_DRIVE_PLL: begin
            if (tmr_expired) begin
               state_d  = ST_DRIVE_ALL;
               tmr_load = 1'b1;
               tmr_val  = LD_SETUP;
            end
         end
         ST_DRIVE_ALL: begin
            if (tmr_expired)
               state_d = ST_RELEASE_RESET;
         end
         ST_RELEASE_RESET: begin
            state_d  = ST_HOLD;
            tmr_load = 1'b1;
            tmr_val  = LD_HOLD;
         end
         ST_HOLD: begin
            if (tmr_expired)
               state_d = ST_TRISTATE;
         end
         ST_TRISTATE: state_d = ST_TRISTATE;
         default:     state_d = ST_IDLE_RESET;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE_RESET;
         hreset_n  <= 1'b0;
         pll_drive <= 1'b0;
         gp_drive  <= 1'b0;
         done      <= 1'b0;
      end else begin
         state_q   <= state_d;
         hreset_n  <= (state_d == ST_RELEASE_RESET) || (state_d == ST_HOLD) ||
                      (state_d == ST_TRISTATE);
         pll_drive <= (state_d != ST_IDLE_RESET) && (state_d != ST_TRISTATE);
         gp_drive  <= (state_d == ST_DRIVE_ALL) || (state_d == ST_RELEASE_RESET) ||
                      (state_d == ST_HOLD);
         done      <= (state_d == ST_TRISTATE);
      end
   end

   assign capture_en = (state_q == ST_IDLE_RESET);

endmodule

// File: rtl/rststrap_drive.sv
module rststrap_drive #(
   parameter int              PLL_W       = 4,
   parameter int              GP_W        = 32,
   parameter logic [GP_W-1:0] GP_USE_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture_en,
   input  logic [PLL_W-1:0] pll_cfg,
   input  logic [GP_W-1:0]  gp_cfg,
   input  logic             pll_drive,
   input  logic             gp_drive,
   output logic [PLL_W-1:0] pll_o,
   output logic [PLL_W-1:0] pll_oe,
   output logic [GP_W-1:0]  gp_o,
   output logic [GP_W-1:0]  gp_oe
);

   logic [PLL_W-1:0] pll_q;
   logic [GP_W-1:0]  gp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_q <= '0;
         gp_q  <= '0;
      end else if (capture_en) begin
         pll_q <= pll_cfg;
         gp_q  <= gp_cfg & GP_USE_MASK;
      end
   end

   assign pll_o = pll_q;
   assign gp_o  = gp_q;

   for (genvar p = 0; p < PLL_W; p++) begin : g_pll_oe
      assign pll_oe[p] = pll_drive;
   end

   for (genvar g = 0; g < GP_W; g++) begin : g_gp_oe
      if (GP_USE_MASK[g]) begin : g_used
         assign gp_oe[g] = gp_drive;
      end else begin : g_unused
         assign gp_oe[g] = 1'b0;
      end
   end

endmodule

// File: rtl/rststrap_seq.sv
module rststrap_seq #(
   parameter int              PLL_W           = 4,
   parameter int              GP_W            = 32,
   parameter logic [GP_W-1:0] GP_USE_MASK     = '1,
   parameter int              CLK_HZ          = 33_333_333,
   parameter int              PLL_SETUP_US    = 100_000,
   parameter int              STRAP_SETUP_CYC = 4,
   parameter int              HOLD_CYC        = 2
) (
   input  logic             clk,
   input  logic             pwr_ok,
   input  logic [PLL_W-1:0] cfg_pll_i,
   input  logic [GP_W-1:0]  cfg_gp_i,
   output logic             hreset_n,
   output logic [PLL_W-1:0] pll_strap_o,
   output logic [PLL_W-1:0] pll_strap_oe,
   output logic [GP_W-1:0]  gp_strap_o,
   output logic [GP_W-1:0]  gp_strap_oe,
   output logic             seq_done
);

   localparam longint unsigned PLL_CYC_L =
      (longint'(CLK_HZ) * longint'(PLL_SETUP_US) + 64'd999_999) / 64'd1_000_000;
   localparam int PLL_SETUP_CYC = int'(PLL_CYC_L);

   if (PLL_W < 1 || GP_W < 1) begin : g_bad_width
      $error("strap bus widths must be at least 1");
   end
   if (STRAP_SETUP_CYC < 4) begin : g_bad_setup
      $error("general strap setup must be at least 4 cycles");
   end
   if (HOLD_CYC < 2) begin : g_bad_hold
      $error("strap hold must be at least 2 cycles");
   end
   if (PLL_SETUP_CYC <= STRAP_SETUP_CYC) begin : g_bad_pll
      $error("PLL setup window must exceed the general strap setup");
   end

   logic capture_en, pll_drive, gp_drive;

   rststrap_fsm #(
      .PLL_CYC   (PLL_SETUP_CYC),
      .SETUP_CYC (STRAP_SETUP_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (pwr_ok),
      .capture_en (capture_en),
      .hreset_n   (hreset_n),
      .pll_drive  (pll_drive),
      .gp_drive   (gp_drive),
      .done       (seq_done)
   );

   rststrap_drive #(
      .PLL_W       (PLL_W),
      .GP_W        (GP_W),
      .GP_USE_MASK (GP_USE_MASK)
   ) u_drive (
      .clk        (clk),
      .rst_n      (pwr_ok),
      .capture_en (capture_en),
      .pll_cfg    (cfg_pll_i),
      .gp_cfg     (cfg_gp_i),
      .pll_drive  (pll_drive),
      .gp_drive   (gp_drive),
      .pll_o      (pll_strap_o),
      .pll_oe     (pll_strap_oe),
      .gp_o       (gp_strap_o),
      .gp_oe      (gp_strap_oe)
   );

endmodule

// File: rtl/rststrap_chk.sv
module rststrap_chk #(
   parameter int              PLL_W       = 4,
   parameter int              GP_W        = 32,
   parameter logic [GP_W-1:0] GP_USE_MASK = '1,
   parameter int              PLL_CYC     = 20,
   parameter int              SETUP_CYC   = 4,
   parameter int              HOLD_CYC    = 2
) (
   input logic             clk,
   input logic             pwr_ok,
   input logic             hreset_n,
   input logic [PLL_W-1:0] pll_strap_o,
   input logic [PLL_W-1:0] pll_strap_oe,
   input logic [GP_W-1:0]  gp_strap_o,
   input logic [GP_W-1:0]  gp_strap_oe,
   input logic             seq_done
);

   int pll_run, gp_run, hi_run;

   always_ff @(posedge clk or negedge pwr_ok) begin
      if (!pwr_ok) begin
         pll_run <= 0;
         gp_run  <= 0;
         hi_run  <= 0;
      end else begin
         pll_run <= pll_strap_oe[0] ? ((pll_run < 32'h3FFF_FFFF) ? pll_run + 1 : pll_run) : 0;
         gp_run  <= (|gp_strap_oe)  ? ((gp_run  < 32'h3FFF_FFFF) ? gp_run  + 1 : gp_run)  : 0;
         hi_run  <= hreset_n        ? ((hi_run  < 32'h3FFF_FFFF) ? hi_run  + 1 : hi_run)  : 0;
      end
   end

   // R2
   a_r2_pll_setup: assert property (@(posedge clk) disable iff (!pwr_ok)
      $rose(hreset_n) |-> (pll_run >= PLL_CYC));
   // R3
   a_r3_gp_setup: assert property (@(posedge clk) disable iff (!pwr_ok)
      ($rose(hreset_n) && (GP_USE_MASK != '0)) |-> (gp_run == SETUP_CYC));
   // R4
   a_r4_no_relapse: assert property (@(posedge clk) disable iff (!pwr_ok)
      hreset_n |=> hreset_n);
   // R5
   a_r5_hold_window: assert property (@(posedge clk) disable iff (!pwr_ok)
      $fell(pll_strap_oe[0]) |-> (hreset_n && hi_run >= HOLD_CYC + 1));
   // R5
   a_r5_oe_on_release: assert property (@(posedge clk) disable iff (!pwr_ok)
      $rose(hreset_n) |-> (pll_strap_oe[0] && ((gp_strap_oe & GP_USE_MASK) == GP_USE_MASK)));
   // R6
   a_r6_values_frozen: assert property (@(posedge clk) disable iff (!pwr_ok)
      (pll_strap_oe[0] && $past(pll_strap_oe[0])) |->
         ($stable(pll_strap_o) && $stable(gp_strap_o)));
   // R7
   a_r7_done_released: assert property (@(posedge clk) disable iff (!pwr_ok)
      seq_done |-> (hreset_n && pll_strap_oe == '0 && gp_strap_oe == '0));
   // R9
   a_r9_masked_idle: assert property (@(posedge clk) disable iff (!pwr_ok)
      ((gp_strap_oe & ~GP_USE_MASK) == '0) && ((gp_strap_o & ~GP_USE_MASK) == '0));

endmodule

bind rststrap_seq rststrap_chk #(
   .PLL_W       (PLL_W),
   .GP_W        (GP_W),
   .GP_USE_MASK (GP_USE_MASK),
   .PLL_CYC     (PLL_SETUP_CYC),
   .SETUP_CYC   (STRAP_SETUP_CYC),
   .HOLD_CYC    (HOLD_CYC)
) u_chk (
   .clk          (clk),
   .pwr_ok       (pwr_ok),
   .hreset_n     (hreset_n),
   .pll_strap_o  (pll_strap_o),
   .pll_strap_oe (pll_strap_oe),
   .gp_strap_o   (gp_strap_o),
   .gp_strap_oe  (gp_strap_oe),
   .seq_done     (seq_done)
);

// File: tb/sim_rststrap_seq.sv
module sim_rststrap_seq;

   localparam int          PLL_W   = 4;
   localparam int          GP_W    = 32;
   localparam logic [31:0] MASK    = 32'hF0FF_FF0F;
   localparam int          S       = 4;
   localparam int          H       = 2;
   localparam int          EXP_PLL = 20;   // ceil(1 MHz * 20 us)

   logic             clk = 1'b0;
   logic             pwr_ok = 1'b1;
   logic [PLL_W-1:0] cfg_pll = '0;
   logic [GP_W-1:0]  cfg_gp = '0;
   logic             hreset_n;
   logic [PLL_W-1:0] pll_strap_o, pll_strap_oe;
   logic [GP_W-1:0]  gp_strap_o, gp_strap_oe;
   logic             seq_done;

   always #5 clk = ~clk;

   rststrap_seq #(
      .PLL_W(PLL_W), .GP_W(GP_W), .GP_USE_MASK(MASK),
      .CLK_HZ(1_000_000), .PLL_SETUP_US(20),
      .STRAP_SETUP_CYC(S), .HOLD_CYC(H)
   ) u0 (
      .clk(clk), .pwr_ok(pwr_ok), .cfg_pll_i(cfg_pll), .cfg_gp_i(cfg_gp),
      .hreset_n(hreset_n), .pll_strap_o(pll_strap_o), .pll_strap_oe(pll_strap_oe),
      .gp_strap_o(gp_strap_o), .gp_strap_oe(gp_strap_oe), .seq_done(seq_done)
   );

   int               checks = 0;
   int               fails  = 0;
   int               n = 0;
   bit               run = 0;
   bit               ended = 0;
   logic             hr_prev = 1'b0;
   logic [PLL_W-1:0] m_pll = '0;
   logic [GP_W-1:0]  m_gp = '0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: edges seen with pwr_ok high, and the captured word
   always @(posedge clk) begin
      if (!pwr_ok) n <= 0;
      else begin
         if (n == 0) begin
            m_pll <= cfg_pll;
            m_gp  <= cfg_gp;
         end
         n <= n + 1;
      end
   end

   always @(negedge clk) begin
      if (run) begin
         logic hr, po, go, dn;
         logic [PLL_W-1:0] pv;
         logic [GP_W-1:0]  gv;
         string t_hr, t_po, t_go;
         hr = pwr_ok && (n >= EXP_PLL + 1);
         po = pwr_ok && (n >= 1) && (n <= EXP_PLL + H + 1);
         go = pwr_ok && (n >= EXP_PLL - S + 1) && (n <= EXP_PLL + H + 1);
         dn = pwr_ok && (n >= EXP_PLL + H + 2);
         pv = (pwr_ok && n >= 1) ? m_pll : '0;
         gv = (pwr_ok && n >= 1) ? (m_gp & MASK) : '0;
         t_hr = !pwr_ok ? "R1" : "R4";
         t_po = !pwr_ok ? "R1" : ((n > EXP_PLL) ? "R5" : "R2");
         t_go = !pwr_ok ? "R1" : ((n > EXP_PLL) ? "R5" : "R3");
         chk(t_hr, 64'(hreset_n), 64'(hr));
         chk(t_po, 64'(pll_strap_oe), po ? 64'({PLL_W{1'b1}}) : 64'd0);
         chk(t_go, 64'(gp_strap_oe), go ? 64'(MASK) : 64'd0);
         chk(pwr_ok ? "R6" : "R1", 64'(pll_strap_o), 64'(pv));
         chk(pwr_ok ? "R6" : "R1", 64'(gp_strap_o), 64'(gv));
         chk(pwr_ok ? "R7" : "R1", 64'(seq_done), 64'(dn));
         if (hreset_n === 1'b1 && hr_prev === 1'b0)
            chk("R10", 64'(n), 64'(EXP_PLL + 1));
         hr_prev = hreset_n;
      end
   end

   task automatic cyc(input int k);
      repeat (k) @(posedge clk);
      #3;
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      finish_run();
   end

   initial begin
      #2 pwr_ok = 1'b0;
      #2 run = 1;
      cyc(5);                                   // R1 reset state
      cfg_pll = 4'hA; cfg_gp = 32'h1234_5678;
      pwr_ok = 1'b1;
      cyc(3);
      cfg_pll = 4'h5; cfg_gp = 32'hDEAD_BEEF;   // R6: must not reach pins
      cyc(30);
      cfg_pll = 4'hC; cfg_gp = 32'h0000_0001;   // R6/R7: ignored after done
      cyc(5);
      // R8: request during the all-strap window
      pwr_ok = 1'b0; cyc(3);
      cfg_pll = 4'h3; cfg_gp = 32'hFFFF_FFFF;
      pwr_ok = 1'b1; cyc(18);
      pwr_ok = 1'b0;
      @(negedge clk);
      chk("R8", {62'd0, hreset_n, pll_strap_oe[0]}, 64'd0);
      cyc(2);
      // R8: request during hold
      pwr_ok = 1'b1; cyc(22);
      pwr_ok = 1'b0;
      @(negedge clk);
      chk("R8", 64'({hreset_n, pll_strap_oe, gp_strap_oe}), 64'd0);
      cyc(2);
      // full run with all-ones word: masked bits stay quiet
      pwr_ok = 1'b1; cyc(19);
      @(negedge clk);
      chk("R9", 64'(gp_strap_o & ~MASK), 64'd0);
      chk("R9", 64'(gp_strap_oe & ~MASK), 64'd0);
      chk("R9", 64'(gp_strap_o), 64'(MASK));
      cyc(15);
      finish_run();
   end

endmodule